// File: doc/BRIEF.md
# Page-walk memory request scheduler

This block stands between a hardware page-table walker and the memory port that the walker uses. It holds one pending read (the next table entry the walker wants) and a small stack of pending write-backs (entries whose accessed flag the walker has updated). It presents one request per cycle to a port that can refuse the request outright or accept it and later answer it with a negative acknowledgement. A good read answer goes straight back to the walker. The walker then returns a step, which can carry the next read and one write-back. The scheduler reports the end of a walk once every piece of traffic belonging to that walk has drained.

Control is a four-state machine. IDLE waits for a start. RUN issues traffic. STALL holds all issue after a refusal. FIN is a one-cycle completion pulse. The transitions are as follows. IDLE goes to RUN on a start. RUN goes to STALL when the port refuses the presented request. RUN goes to FIN when nothing is pending, nothing is in flight and the walker holds no answer. STALL goes back to RUN on a retry pulse. FIN always returns to IDLE. Responses and walker steps are absorbed in every state.

Top module: `walk_mem_sched`

## Requirements
- R1: In IDLE, `walk_start` loads `walk_addr` into the read slot and the read is presented on the cycle after the start. A start seen in any other state is ignored.
- R2: While the read slot is full and the state is RUN, the presented request is that read (`req_write`=0, `req_data`=0), even when write-backs are queued.
- R3: With no read pending, queued write-backs are presented one per cycle (`req_write`=1) in last-in, first-out order until the stack is empty or the port refuses.
- R4: A presented request with `req_ok`=0 is not consumed. From the next cycle nothing is presented until a `retry` pulse arrives, and the same request is presented on the cycle after that pulse.
- R5: A response with `rsp_nack`=0 and `rsp_write`=0 is forwarded in the same cycle on `wk_rsp_valid`/`wk_rsp_data`, and the walker is then considered to hold it.
- R6: A response with `rsp_nack`=1 returns the request it names to pending. A read goes back into the read slot. A write (address and data from the response) goes onto the top of the write stack. The request is then reissued under the normal priority.
- R7: `step_ready` is high only while the walker holds an answer, the write stack entries plus writes in flight are fewer than WB_DEPTH, and no negatively acknowledged write is arriving. An accepted step loads its optional read and pushes its optional write-back. A step offered while `step_ready` is low has no effect.
- R8: `walk_done` pulses for exactly one cycle when, in RUN, no read is pending, the write stack is empty, the in-flight count is zero and the walker holds no answer. It stays low at all other times.
- R9: Reset clears the read slot, the write stack, both in-flight counts, the walker-hold flag and the state (IDLE). After reset no request is presented and nothing from before the reset is reissued.
- R10: A `retry` pulse outside STALL has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| walk_start | input | 1 | Begin a walk (honoured in IDLE only) |
| walk_addr | input | ADDR_W | Address of the first table read |
| step_valid | input | 1 | Walker offers a step |
| step_ready | output | 1 | Step is accepted this cycle |
| step_rd | input | 1 | Step carries a next read |
| step_rd_addr | input | ADDR_W | Address of the next read |
| step_wb | input | 1 | Step carries a write-back |
| step_wb_addr | input | ADDR_W | Write-back address |
| step_wb_data | input | DATA_W | Write-back data |
| wk_rsp_valid | output | 1 | Good read answer to the walker |
| wk_rsp_data | output | DATA_W | Read answer data |
| req_valid | output | 1 | Request presented to memory |
| req_write | output | 1 | 1 write, 0 read |
| req_addr | output | ADDR_W | Request address |
| req_data | output | DATA_W | Write data (zero for reads) |
| req_ok | input | 1 | Port accepts the presented request |
| retry | input | 1 | Port may be tried again |
| rsp_valid | input | 1 | Memory response |
| rsp_nack | input | 1 | Response is a negative acknowledgement |
| rsp_write | input | 1 | Response belongs to a write |
| rsp_addr | input | ADDR_W | Address of the answered request |
| rsp_data | input | DATA_W | Read data, or write data of a nacked write |
| walk_done | output | 1 | One-cycle completion pulse |

## Verification
The bench drives several cases. It queues a read behind pending write-backs: a scheduler that ignores read priority would send a write first. It refuses a read and withholds `retry` for several cycles: a design that keeps issuing during a stall, or that drops the refused request, would present traffic or skip the read. It nacks three in-flight writes during a stall, after which the drain order shows whether the stack is truly last-in, first-out. It fills the stack with writes in flight and offers a step: a design that counts only queued entries would accept the step and overflow. It also checks that completion waits for the last write response and the walker's final step. A premature `walk_done` would appear while a read answer is still with the walker.

// File: rtl/wms_pkg.sv
package wms_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_STALL = 2'd2,
        ST_FIN   = 2'd3
    } wms_state_e;

endpackage

// File: rtl/wms_fsm.sv
module wms_fsm
    import wms_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       refused,
    input  logic       retry,
    input  logic       drained,
    output wms_state_e state,
    output logic       is_idle,
    output logic       issue_en,
    output logic       walk_done
);

    wms_state_e state_nx;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start)   state_nx = ST_RUN;
            ST_RUN: begin
                if (refused)       state_nx = ST_STALL;
                else if (drained)  state_nx = ST_FIN;
            end
            ST_STALL: if (retry)   state_nx = ST_RUN;
            ST_FIN:                state_nx = ST_IDLE;
            default:               state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // outputs decoded from state
    always_comb begin
        is_idle   = 1'b0;
        issue_en  = 1'b0;
        walk_done = 1'b0;
        unique case (state)
            ST_IDLE:  is_idle   = 1'b1;
            ST_RUN:   issue_en  = 1'b1;
            ST_STALL: ;
            ST_FIN:   walk_done = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/wms_wb_lifo.sv
module wms_wb_lifo #(
    parameter int AW    = 40,
    parameter int DW    = 64,
    parameter int DEPTH = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             push,
    input  logic [AW-1:0]                    push_addr,
    input  logic [DW-1:0]                    push_data,
    input  logic                             pop,
    output logic [AW-1:0]                    top_addr,
    output logic [DW-1:0]                    top_data,
    output logic                             empty,
    output logic [$clog2(DEPTH+1)-1:0]       count
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0][AW-1:0] addr_flat;
    logic [DEPTH-1:0][DW-1:0] data_flat;
    logic [CW-1:0]            wr_idx;
    logic [IW-1:0]            top_idx;

    // a pop in the same cycle frees the top slot for the push
    assign wr_idx  = count - CW'(pop);
    assign top_idx = IW'(count - CW'(1));
    assign empty   = (count == '0);

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [AW-1:0] a_r;
        logic [DW-1:0] d_r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                a_r <= '0;
                d_r <= '0;
            end else if (push && (wr_idx == CW'(i))) begin
                a_r <= push_addr;
                d_r <= push_data;
            end
        end
        assign addr_flat[i] = a_r;
        assign data_flat[i] = d_r;
    end

    assign top_addr = addr_flat[top_idx];
    assign top_data = data_flat[top_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count <= '0;
        else        count <= count - CW'(pop) + CW'(push);
    end

endmodule

// File: rtl/wms_flight.sv
module wms_flight #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc,
    input  logic          acc_wr,
    input  logic          rsp,
    input  logic          rsp_wr,
    output logic [CW-1:0] total,
    output logic [CW-1:0] writes
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total  <= '0;
            writes <= '0;
        end else begin
            total  <= total  + CW'(acc)              - CW'(rsp);
            writes <= writes + CW'(acc && acc_wr)    - CW'(rsp && rsp_wr);
        end
    end

endmodule

// File: rtl/walk_mem_sched.sv
module walk_mem_sched
    import wms_pkg::*;
#(
    parameter int ADDR_W   = 40,
    parameter int DATA_W   = 64,
    parameter int WB_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              walk_start,
    input  logic [ADDR_W-1:0] walk_addr,
    input  logic              step_valid,
    output logic              step_ready,
    input  logic              step_rd,
    input  logic [ADDR_W-1:0] step_rd_addr,
    input  logic              step_wb,
    input  logic [ADDR_W-1:0] step_wb_addr,
    input  logic [DATA_W-1:0] step_wb_data,
    output logic              wk_rsp_valid,
    output logic [DATA_W-1:0] wk_rsp_data,
    output logic              req_valid,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    input  logic              req_ok,
    input  logic              retry,
    input  logic              rsp_valid,
    input  logic              rsp_nack,
    input  logic              rsp_write,
    input  logic [ADDR_W-1:0] rsp_addr,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              walk_done
);

    localparam int QCW = $clog2(WB_DEPTH + 1);
    localparam int FCW = $clog2(WB_DEPTH + 2);
    localparam int SW  = FCW + 1;

    wms_state_e        state;
    logic              is_idle, issue_en;
    logic              rd_pend;
    logic [ADDR_W-1:0] rd_addr;
    logic              holding;
    logic              q_empty;
    logic [QCW-1:0]    qcount;
    logic [ADDR_W-1:0] q_top_addr;
    logic [DATA_W-1:0] q_top_data;
    logic [FCW-1:0]    inflight, wr_out;
    logic              acc, refused, drained, start_take;
    logic              good_rd, nack_rd, nack_wr, step_take;
    logic              q_push, q_pop;
    logic [ADDR_W-1:0] q_push_addr;
    logic [DATA_W-1:0] q_push_data;
    logic [SW-1:0]     room_used;

    // request selection: the read slot always wins
    assign req_valid = issue_en && (rd_pend || !q_empty);
    assign req_write = !rd_pend;
    assign req_addr  = rd_pend ? rd_addr : q_top_addr;
    assign req_data  = rd_pend ? '0      : q_top_data;
    assign acc       = req_valid && req_ok;
    assign refused   = req_valid && !req_ok;

    // response classification
    assign good_rd = rsp_valid && !rsp_nack && !rsp_write;
    assign nack_rd = rsp_valid &&  rsp_nack && !rsp_write;
    assign nack_wr = rsp_valid &&  rsp_nack &&  rsp_write;

    assign wk_rsp_valid = good_rd;
    assign wk_rsp_data  = rsp_data;

    // stack space is reserved for writes still in flight
    assign room_used  = SW'(qcount) + SW'(wr_out);
    assign step_ready = holding && (room_used < SW'(WB_DEPTH)) && !nack_wr;
    assign step_take  = step_valid && step_ready;

    assign start_take = walk_start && is_idle;
    assign drained    = !rd_pend && q_empty && (inflight == '0) && !holding;

    assign q_pop       = acc && !rd_pend;
    assign q_push      = nack_wr || (step_take && step_wb);
    assign q_push_addr = nack_wr ? rsp_addr : step_wb_addr;
    assign q_push_data = nack_wr ? rsp_data : step_wb_data;

    // pending read slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_pend <= 1'b0;
            rd_addr <= '0;
        end else if (start_take) begin
            rd_pend <= 1'b1;
            rd_addr <= walk_addr;
        end else begin
            if (acc && rd_pend) rd_pend <= 1'b0;
            if (nack_rd) begin
                rd_pend <= 1'b1;
                rd_addr <= rsp_addr;
            end else if (step_take && step_rd) begin
                rd_pend <= 1'b1;
                rd_addr <= step_rd_addr;
            end
        end
    end

    // walker holds a read answer until it returns a step
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         holding <= 1'b0;
        else if (good_rd)   holding <= 1'b1;
        else if (step_take) holding <= 1'b0;
    end

    wms_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_take),
        .refused   (refused),
        .retry     (retry),
        .drained   (drained),
        .state     (state),
        .is_idle   (is_idle),
        .issue_en  (issue_en),
        .walk_done (walk_done)
    );

    wms_wb_lifo #(
        .AW    (ADDR_W),
        .DW    (DATA_W),
        .DEPTH (WB_DEPTH)
    ) u_lifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_addr (q_push_addr),
        .push_data (q_push_data),
        .pop       (q_pop),
        .top_addr  (q_top_addr),
        .top_data  (q_top_data),
        .empty     (q_empty),
        .count     (qcount)
    );

    wms_flight #(
        .CW (FCW)
    ) u_flight (
        .clk    (clk),
        .rst_n  (rst_n),
        .acc    (acc),
        .acc_wr (req_write),
        .rsp    (rsp_valid),
        .rsp_wr (rsp_write),
        .total  (inflight),
        .writes (wr_out)
    );

endmodule

// File: rtl/wms_sched_chk.sv
module wms_sched_chk
    import wms_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int QCW   = 3,
    parameter int FCW   = 3
) (
    input logic           clk,
    input logic           rst_n,
    input wms_state_e     state,
    input logic           rd_pend,
    input logic [QCW-1:0] qcount,
    input logic [FCW-1:0] inflight,
    input logic [FCW-1:0] wr_out,
    input logic           req_valid,
    input logic           req_write,
    input logic           req_ok,
    input logic           retry,
    input logic           walk_done
);

    // R2: a pending read in RUN is what the port sees
    assert_read_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && rd_pend) |-> (req_valid && !req_write));

    // R4: a refusal silences the port on the next cycle
    assert_halt_after_refuse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ok) |=> !req_valid);

    // R4: STALL is left only through a retry
    assert_stall_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STALL && !retry) |=> (state == ST_STALL));

    // R8: completion only once everything has drained
    assert_done_drained_R8: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |-> (inflight == '0 && qcount == '0 && !rd_pend));

    // R8: completion is a single-cycle pulse
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |=> !walk_done);

    // R7: queued plus in-flight writes never exceed the stack depth
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(qcount) + int'(wr_out)) <= DEPTH);

    // R10: a retry in RUN keeps the machine in RUN unless a refusal occurs
    assert_retry_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && retry && !(req_valid && !req_ok) && rd_pend) |=> (state == ST_RUN));

endmodule

bind walk_mem_sched wms_sched_chk #(
    .DEPTH (WB_DEPTH),
    .QCW   (QCW),
    .FCW   (FCW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .rd_pend   (rd_pend),
    .qcount    (qcount),
    .inflight  (inflight),
    .wr_out    (wr_out),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ok    (req_ok),
    .retry     (retry),
    .walk_done (walk_done)
);

// File: tb/walk_mem_sched_tb_top.sv
module walk_mem_sched_tb_top;

    localparam int AW = 40;
    localparam int DW = 64;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          walk_start = 1'b0;
    logic [AW-1:0] walk_addr = '0;
    logic          step_valid = 1'b0, step_rd = 1'b0, step_wb = 1'b0;
    logic [AW-1:0] step_rd_addr = '0, step_wb_addr = '0;
    logic [DW-1:0] step_wb_data = '0;
    logic          step_ready, wk_rsp_valid;
    logic [DW-1:0] wk_rsp_data;
    logic          req_valid, req_write;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_data;
    logic          req_ok = 1'b1, retry = 1'b0;
    logic          rsp_valid = 1'b0, rsp_nack = 1'b0, rsp_write = 1'b0;
    logic [AW-1:0] rsp_addr = '0;
    logic [DW-1:0] rsp_data = '0;
    logic          walk_done;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    ended = 1'b0;
    string tag = "R9";

    always #10 clk = ~clk;

    walk_mem_sched #(.ADDR_W(AW), .DATA_W(DW), .WB_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .walk_start(walk_start), .walk_addr(walk_addr),
        .step_valid(step_valid), .step_ready(step_ready), .step_rd(step_rd),
        .step_rd_addr(step_rd_addr), .step_wb(step_wb), .step_wb_addr(step_wb_addr),
        .step_wb_data(step_wb_data), .wk_rsp_valid(wk_rsp_valid), .wk_rsp_data(wk_rsp_data),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_data(req_data),
        .req_ok(req_ok), .retry(retry), .rsp_valid(rsp_valid), .rsp_nack(rsp_nack),
        .rsp_write(rsp_write), .rsp_addr(rsp_addr), .rsp_data(rsp_data), .walk_done(walk_done)
    );

    // ---------------- behavioural reference model ----------------
    int                 m_st = 0;      // 0 idle, 1 run, 2 stall, 3 fin
    bit                 m_rdp = 1'b0;
    logic [AW-1:0]      m_raddr = '0;
    int                 m_infl = 0;
    int                 m_wro = 0;
    bit                 m_hold = 1'b0;
    logic [AW+DW-1:0]   m_q[$];
    bit                 m_live = 1'b0;

    function automatic bit m_ready();
        return m_hold && (m_q.size() + m_wro < DEPTH) && !(rsp_valid && rsp_nack && rsp_write);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_st = 0; m_rdp = 0; m_raddr = '0; m_infl = 0; m_wro = 0; m_hold = 0;
            m_q.delete();
            m_live = 1'b1;
        end else begin
            bit v, isrd, acc, rdy, drn;
            int nst;
            v    = (m_st == 1) && (m_rdp || m_q.size() > 0);
            isrd = m_rdp;
            acc  = v && req_ok;
            rdy  = m_ready();
            drn  = !m_rdp && m_q.size() == 0 && m_infl == 0 && !m_hold;
            nst  = m_st;
            case (m_st)
                0: if (walk_start) begin nst = 1; m_rdp = 1; m_raddr = walk_addr; end
                1: if (v && !req_ok) nst = 2; else if (drn) nst = 3;
                2: if (retry) nst = 1;
                default: nst = 0;
            endcase
            if (acc) begin
                if (isrd) m_rdp = 0;
                else begin void'(m_q.pop_back()); m_wro++; end
                m_infl++;
            end
            if (rsp_valid) begin
                m_infl--;
                if (rsp_write) m_wro--;
                if (rsp_nack) begin
                    if (rsp_write) m_q.push_back({rsp_addr, rsp_data});
                    else begin m_rdp = 1; m_raddr = rsp_addr; end
                end else if (!rsp_write) m_hold = 1;
            end
            if (step_valid && rdy) begin
                m_hold = 0;
                if (step_rd) begin m_rdp = 1; m_raddr = step_rd_addr; end
                if (step_wb) m_q.push_back({step_wb_addr, step_wb_data});
            end
            m_st = nst;
        end
    end

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the clock edge
    always @(negedge clk) begin
        #2;
        if (rst_n && m_live && !ended) begin
            bit ev;
            logic [63:0] act, exp;
            ev  = (m_st == 1) && (m_rdp || m_q.size() > 0);
            act = {55'd0, req_valid, step_ready, walk_done, wk_rsp_valid, 4'd0, 1'b0};
            exp = {55'd0, ev, m_ready(), (m_st == 3), (rsp_valid && !rsp_nack && !rsp_write), 4'd0, 1'b0};
            chk(tag, "model flags", act, exp);
            if (ev && req_valid) begin
                if (m_rdp) chk(tag, "model req", {23'd0, req_write, req_addr}, {23'd0, 1'b0, m_raddr});
                else       chk(tag, "model req", {23'd0, req_write, req_addr}, {23'd0, 1'b1, m_q[$][AW+DW-1:DW]});
            end
        end
    end

    task automatic report();
        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (cyc > 20000 && !ended) begin
            n_fail++;
            $display("FAIL R8 watchdog expired actual=%0d expected=<20000", cyc);
            report();
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        walk_start = 0; step_valid = 0; step_rd = 0; step_wb = 0;
        rsp_valid = 0; rsp_nack = 0; rsp_write = 0; retry = 0;
    endtask

    task automatic respond(input bit wr, input bit nk, input logic [AW-1:0] a, input logic [DW-1:0] d);
        rsp_valid = 1; rsp_write = wr; rsp_nack = nk; rsp_addr = a; rsp_data = d;
    endtask

    task automatic step(input bit rd, input logic [AW-1:0] ra, input bit wb, input logic [AW-1:0] wa, input logic [DW-1:0] wd);
        step_valid = 1; step_rd = rd; step_rd_addr = ra; step_wb = wb; step_wb_addr = wa; step_wb_data = wd;
    endtask

    task automatic expect_req(input string rq, input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        #1;
        chk(rq, "req_valid", 64'(req_valid), 64'd1);
        chk(rq, "req_write", 64'(req_write), 64'(wr));
        chk(rq, "req_addr", 64'(req_addr), 64'(a));
        chk(rq, "req_data", req_data, d);
    endtask

    initial begin
        // R9: reset state
        tick(); tick(); tick();
        rst_n = 1;
        #1;
        chk("R9", "req_valid after reset", 64'(req_valid), 64'd0);
        chk("R9", "walk_done after reset", 64'(walk_done), 64'd0);
        chk("R9", "step_ready after reset", 64'(step_ready), 64'd0);

        // R1: start loads the read
        tag = "R1";
        walk_start = 1; walk_addr = 40'h1000;
        tick();
        expect_req("R1", 0, 40'h1000, 0);
        walk_start = 1; walk_addr = 40'h9000;   // ignored outside IDLE
        tick();
        #1 chk("R1", "second start ignored", 64'(req_valid), 64'd0);

        // R5: good read forwarded
        tag = "R5";
        respond(0, 0, 40'h1000, 64'hAAAA);
        #1;
        chk("R5", "wk_rsp_valid", 64'(wk_rsp_valid), 64'd1);
        chk("R5", "wk_rsp_data", wk_rsp_data, 64'hAAAA);
        tick();

        // R7 / R10: step accepted, retry in RUN ignored
        tag = "R7";
        #1 chk("R7", "step_ready while holding", 64'(step_ready), 64'd1);
        retry = 1;
        step(1, 40'h2000, 1, 40'h500, 64'h55);
        tick();

        // R2 then R4: read first, refused, stall
        tag = "R2";
        expect_req("R2", 0, 40'h2000, 0);
        req_ok = 0;
        tick();
        req_ok = 1;
        tag = "R4";
        #1 chk("R4", "stall cycle 1", 64'(req_valid), 64'd0);
        tick();
        #1 chk("R4", "stall cycle 2", 64'(req_valid), 64'd0);
        retry = 1;
        tick();
        expect_req("R4", 0, 40'h2000, 0);
        tick();
        tag = "R3";
        expect_req("R3", 1, 40'h500, 64'h55);
        tick();

        // R6: nacked read reissued
        tag = "R6";
        respond(0, 1, 40'h2000, 0);
        tick();
        expect_req("R6", 0, 40'h2000, 0);
        tick();
        respond(1, 0, 40'h500, 64'h55);
        tick();
        respond(0, 0, 40'h2000, 64'hBB);
        tick();

        // build three writes in flight
        tag = "R3";
        for (int k = 0; k < 3; k++) begin
            step(1, 40'h3000 + 40'(k) * 40'h100, 1, 40'h600 + 40'(k) * 40'h10, 64'(k + 1));
            tick();
            tick();   // read accepted
            tick();   // write accepted
            respond(0, 0, 40'h3000 + 40'(k) * 40'h100, 64'(k));
            tick();
        end
        tag = "R7";
        #1 chk("R7", "step_ready with three writes out", 64'(step_ready), 64'd1);
        step(1, 40'h4000, 1, 40'h900, 64'h99);
        tick();
        tag = "R4";
        req_ok = 0;
        tick();        // read refused, STALL
        req_ok = 1;
        tag = "R6";
        for (int k = 0; k < 3; k++) begin
            respond(1, 1, 40'h600 + 40'(k) * 40'h10, 64'(k + 1));
            tick();
        end
        retry = 1;
        tick();
        tag = "R2";
        expect_req("R2", 0, 40'h4000, 0);
        tick();
        tag = "R3";
        expect_req("R3", 1, 40'h620, 64'd3);
        tick();
        expect_req("R3", 1, 40'h610, 64'd2);
        tick();
        expect_req("R3", 1, 40'h600, 64'd1);
        tick();
        expect_req("R3", 1, 40'h900, 64'h99);
        tick();
        #1 chk("R3", "stack empty", 64'(req_valid), 64'd0);

        // R7: full stack blocks steps
        tag = "R7";
        respond(0, 0, 40'h4000, 64'h44);
        tick();
        #1 chk("R7", "step_ready when full", 64'(step_ready), 64'd0);
        step(0, 0, 1, 40'hDEAD, 64'hDEAD);
        tick();
        #1 chk("R7", "ignored step pushed nothing", 64'(req_valid), 64'd0);
        respond(1, 0, 40'h620, 64'd3);
        tick();
        #1 chk("R7", "step_ready after write drains", 64'(step_ready), 64'd1);
        step(0, 0, 1, 40'hA00, 64'hAA);
        tick();
        expect_req("R7", 1, 40'hA00, 64'hAA);
        tick();

        // R8: completion after last response
        tag = "R8";
        respond(1, 0, 40'h610, 64'd2);  tick();
        #1 chk("R8", "no early done", 64'(walk_done), 64'd0);
        respond(1, 0, 40'h600, 64'd1);  tick();
        respond(1, 0, 40'h900, 64'h99); tick();
        respond(1, 0, 40'hA00, 64'hAA); tick();
        #1 chk("R8", "done one cycle after drain", 64'(walk_done), 64'd0);
        tick();
        #1 chk("R8", "done pulse", 64'(walk_done), 64'd1);
        tick();
        #1 chk("R8", "done pulse ends", 64'(walk_done), 64'd0);

        // R9: reset mid-walk
        tag = "R9";
        walk_start = 1; walk_addr = 40'h7000;
        tick();
        tick();
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
        #1;
        chk("R9", "req_valid after mid-walk reset", 64'(req_valid), 64'd0);
        chk("R9", "step_ready after mid-walk reset", 64'(step_ready), 64'd0);
        walk_start = 1; walk_addr = 40'h8000;
        tick();
        expect_req("R9", 0, 40'h8000, 0);
        tick();
        respond(0, 0, 40'h8000, 64'h88);
        tick();
        step(0, 0, 0, 0, 0);
        tick();
        #1 chk("R9", "no stale traffic", 64'(req_valid), 64'd0);
        tick();
        #1 chk("R8", "fresh walk completes", 64'(walk_done), 64'd1);
        tick();
        report();
    end

endmodule